// File: doc/BRIEF.md
# Line Scan Readout Sequencer

This block is a cycle-level digital model of the sequencer that sits beside a linear photodiode array. It is fed the sensor's line clock and line reset as plain inputs. A free-running system clock at twice the line clock rate samples both inputs. The block tracks the window during which charge is collected. After the line reset is released it steps through a fixed number of pixel channels. For each channel it reports which pixel is on the video line, when that pixel is valid, a mid-window sample strobe, and an end-of-scan pulse. When no scan is running it shows that the video line is floating.

Position inside a scan is kept in half line-clock units, so that windows sitting half a clock off a line-clock edge can be represented exactly. The unit counts every line clock transition seen after synchronisation. Several copies can share the line clock and line reset and read out one after another. The first copy runs as a master. Each later copy runs as a follower whose start input is wired to the end-of-scan output of the copy before it.

Top module: `linescan_seq`

## Requirements
- R1: While rst_n is low and after it is released with no line activity, pix_valid, sample_strobe, scan_done, integ_active and overrun are 0, and pix_hiz is 1.
- R2: Counting the first line_clk falling edge after line_rst falls as clock 1, and defining half-position h = 2k at the k-th falling edge and h = 2k+1 at the rising edge after it, a master's scan begins at h = 2, where pix_hiz drops to 0. It stays 0 until h = 8*NCH+36.
- R3: Channel c (0-based) is shown with pix_valid = 1 and pix_idx = c for h from 37+8c up to, but not including, 41+8c. This gives one channel per four line clocks. Outside these windows pix_valid is 0.
- R4: sample_strobe is 1 for h from 39+8c up to, but not including, 41+8c. It is the second half of each channel window, so there is one strobe rise per channel.
- R5: scan_done is 1 for h from 8*NCH+32 up to, but not including, 8*NCH+36. At 8*NCH+36 the scan ends, and pix_hiz returns to 1 until the next scan.
- R6: A follower (slave_mode = 1) ignores the first falling edge after line_rst falls. It starts on the first line clock edge at which start_in is 1, and takes the half-position 37 at that edge, so its channel 0 follows the preceding copy's last channel without a gap.
- R7: In master mode (slave_mode = 0), start_in has no effect on when or how the scan runs.
- R8: integ_active rises at the 8th line_clk falling edge after line_rst rises, and falls at the 8th falling edge after line_rst falls.
- R9: A line_rst rise while the unit is scanning does not disturb the scan in progress. Such a rise sets overrun, which stays 1 until rst_n. A rise while the unit is idle or waiting to start leaves overrun at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the line clock rate or faster |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk | input | 1 | Sensor line clock, sampled and edge-detected |
| line_rst | input | 1 | Sensor line reset; high sets up integration, its fall starts readout |
| slave_mode | input | 1 | Static: 0 master, 1 follower in a chain |
| start_in | input | 1 | Follower start, wired to the preceding copy's scan_done |
| pix_idx | output | clog2(NCH) | Channel currently on the video line |
| pix_valid | output | 1 | Video for pix_idx is valid |
| pix_hiz | output | 1 | Video line is floating (no scan running) |
| sample_strobe | output | 1 | Recommended sampling window inside each channel |
| scan_done | output | 1 | End-of-scan pulse |
| integ_active | output | 1 | Effective charge-integration window |
| overrun | output | 1 | Sticky: line reset rose during a scan |

## Verification
The hardest condition to reach is a line reset rise that lands inside a channel window of a running scan. It must hit exactly while a follower in the same chain is still waiting for its start. The bench runs a master and a follower on shared line signals and tracks the half-position from its own edge counts. It raises line_rst on the rising edge that opens the window of channel 8. Every output of both units is then compared at every half-clock through the rest of that scan, the follower's hand-off, and one further clean scan. This shows that the scan ran on, that only the master flagged the overrun, and that the flag stayed set.

// File: rtl/linescan_pkg.sv
package linescan_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_SCAN  = 2'd2
   } seq_state_e;

   // Half line-clock positions; the first falling edge after release is clock 1.
   localparam int START_HALF  = 2;
   localparam int LEAD_HALF   = 37;
   localparam int SLOT_HALF   = 8;
   localparam int VALID_HALF  = 4;
   localparam int STROBE_OFS  = 2;

endpackage

// File: rtl/linescan_sync.sv
module linescan_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_clk,
   input  logic line_rst,
   output logic edge_any,
   output logic edge_fall,
   output logic rst_rise,
   output logic rst_fall
);

   logic [STAGES:0] c_sh;
   logic [STAGES:0] r_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_sh <= '0;
         r_sh <= '0;
      end else begin
         c_sh <= {c_sh[STAGES-1:0], line_clk};
         r_sh <= {r_sh[STAGES-1:0], line_rst};
      end
   end

   assign edge_any  = c_sh[STAGES] ^ c_sh[STAGES-1];
   assign edge_fall = c_sh[STAGES] & ~c_sh[STAGES-1];
   assign rst_rise  = ~r_sh[STAGES] & r_sh[STAGES-1];
   assign rst_fall  = r_sh[STAGES] & ~r_sh[STAGES-1];

endmodule

// File: rtl/linescan_integ.sv
module linescan_integ #(
   parameter int DLY = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_fall,
   input  logic rst_rise,
   input  logic rst_fall,
   output logic integ_active
);

   localparam int CNT_W = $clog2(DLY + 1);

   logic [CNT_W-1:0] cnt;
   logic             target;
   logic             pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt          <= '0;
         target       <= 1'b0;
         pending      <= 1'b0;
         integ_active <= 1'b0;
      end else if (rst_rise) begin
         cnt     <= '0;
         target  <= 1'b1;
         pending <= 1'b1;
      end else if (rst_fall) begin
         cnt     <= '0;
         target  <= 1'b0;
         pending <= 1'b1;
      end else if (pending && edge_fall) begin
         if (cnt == CNT_W'(DLY - 1)) begin
            integ_active <= target;
            pending      <= 1'b0;
         end
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/linescan_ctrl.sv
module linescan_ctrl
   import linescan_pkg::*;
#(
   parameter int PW        = 12,
   parameter int START_POS = 2,
   parameter int LEAD      = 37,
   parameter int END_POS   = 548
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_any,
   input  logic          edge_fall,
   input  logic          rst_rise,
   input  logic          rst_fall,
   input  logic          slave_mode,
   input  logic          start_in,
   output logic          active,
   output logic [PW-1:0] pos,
   output logic          overrun
);

   seq_state_e state;
   logic       go;

   assign go     = edge_any && (slave_mode ? start_in : edge_fall);
   assign active = (state == ST_SCAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pos     <= '0;
         overrun <= 1'b0;
      end else begin
         if (rst_rise && state == ST_SCAN)
            overrun <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (rst_fall)
                  state <= ST_ARMED;
            end
            ST_ARMED: begin
               if (go) begin
                  state <= ST_SCAN;
                  pos   <= slave_mode ? PW'(LEAD) : PW'(START_POS);
               end
            end
            ST_SCAN: begin
               if (edge_any) begin
                  if (pos == PW'(END_POS - 1)) begin
                     state <= ST_IDLE;
                     pos   <= '0;
                  end else begin
                     pos <= pos + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/linescan_decode.sv
module linescan_decode #(
   parameter int NCH        = 256,
   parameter int PW         = 12,
   parameter int IDX_W      = 8,
   parameter int LEAD       = 37,
   parameter int SLOT       = 8,
   parameter int VALID      = 4,
   parameter int STROBE_OFS = 2,
   parameter int EOS_START  = 2080,
   parameter int EOS_END    = 2084
) (
   input  logic             active,
   input  logic [PW-1:0]    pos,
   output logic [IDX_W-1:0] idx,
   output logic             valid,
   output logic             strobe,
   output logic             done
);

   logic [PW-1:0] off;
   logic [PW-1:0] slot;
   logic [PW-1:0] phase;
   logic          in_span;

   assign off = pos - PW'(LEAD);

   generate
      if ((SLOT & (SLOT - 1)) == 0) begin : g_pow2
         localparam int SH = $clog2(SLOT);
         assign slot  = off >> SH;
         assign phase = off & PW'(SLOT - 1);
      end else begin : g_div
         assign slot  = off / PW'(SLOT);
         assign phase = off % PW'(SLOT);
      end
   endgenerate

   always_comb begin
      in_span = active && (pos >= PW'(LEAD)) && (slot < PW'(NCH));
      valid   = in_span && (phase < PW'(VALID));
      strobe  = valid && (phase >= PW'(STROBE_OFS));
      idx     = valid ? slot[IDX_W-1:0] : '0;
      done    = active && (pos >= PW'(EOS_START)) && (pos < PW'(EOS_END));
   end

endmodule

// File: rtl/linescan_seq.sv
module linescan_seq
   import linescan_pkg::*;
#(
   parameter int NCH         = 256,
   parameter int SYNC_STAGES = 2,
   parameter int INTEG_DLY   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   line_clk,
   input  logic                   line_rst,
   input  logic                   slave_mode,
   input  logic                   start_in,
   output logic [$clog2(NCH)-1:0] pix_idx,
   output logic                   pix_valid,
   output logic                   pix_hiz,
   output logic                   sample_strobe,
   output logic                   scan_done,
   output logic                   integ_active,
   output logic                   overrun
);

   localparam int IDX_W     = $clog2(NCH);
   localparam int EOS_START = LEAD_HALF + SLOT_HALF * (NCH - 1) + VALID_HALF - 1;
   localparam int EOS_END   = EOS_START + VALID_HALF;
   localparam int POS_W     = $clog2(EOS_END + 1);

   generate
      if (!(NCH == 64 || NCH == 128 || NCH == 256)) begin : g_bad_nch
         initial $fatal(1, "linescan_seq: NCH must be 64, 128 or 256");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         initial $fatal(1, "linescan_seq: SYNC_STAGES must be at least 1");
      end
      if (INTEG_DLY < 1) begin : g_bad_dly
         initial $fatal(1, "linescan_seq: INTEG_DLY must be at least 1");
      end
   endgenerate

   logic             edge_any;
   logic             edge_fall;
   logic             rst_rise;
   logic             rst_fall;
   logic             active;
   logic [POS_W-1:0] pos;

   linescan_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_clk  (line_clk),
      .line_rst  (line_rst),
      .edge_any  (edge_any),
      .edge_fall (edge_fall),
      .rst_rise  (rst_rise),
      .rst_fall  (rst_fall)
   );

   linescan_integ #(.DLY(INTEG_DLY)) u_integ (
      .clk          (clk),
      .rst_n        (rst_n),
      .edge_fall    (edge_fall),
      .rst_rise     (rst_rise),
      .rst_fall     (rst_fall),
      .integ_active (integ_active)
   );

   linescan_ctrl #(
      .PW        (POS_W),
      .START_POS (START_HALF),
      .LEAD      (LEAD_HALF),
      .END_POS   (EOS_END)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_any   (edge_any),
      .edge_fall  (edge_fall),
      .rst_rise   (rst_rise),
      .rst_fall   (rst_fall),
      .slave_mode (slave_mode),
      .start_in   (start_in),
      .active     (active),
      .pos        (pos),
      .overrun    (overrun)
   );

   linescan_decode #(
      .NCH        (NCH),
      .PW         (POS_W),
      .IDX_W      (IDX_W),
      .LEAD       (LEAD_HALF),
      .SLOT       (SLOT_HALF),
      .VALID      (VALID_HALF),
      .STROBE_OFS (STROBE_OFS),
      .EOS_START  (EOS_START),
      .EOS_END    (EOS_END)
   ) u_decode (
      .active (active),
      .pos    (pos),
      .idx    (pix_idx),
      .valid  (pix_valid),
      .strobe (sample_strobe),
      .done   (scan_done)
   );

   assign pix_hiz = ~active;

endmodule

// File: rtl/linescan_seq_chk.sv
module linescan_seq_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] pix_idx,
   input logic             pix_valid,
   input logic             pix_hiz,
   input logic             sample_strobe,
   input logic             scan_done,
   input logic             overrun
);

   assert_valid_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> !pix_hiz);

   assert_idx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && $past(pix_valid)) |-> $stable(pix_idx));

   assert_strobe_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |-> pix_valid);

   assert_done_in_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !pix_hiz);

   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

endmodule

bind linescan_seq linescan_seq_chk #(.IDX_W($clog2(NCH))) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pix_idx       (pix_idx),
   .pix_valid     (pix_valid),
   .pix_hiz       (pix_hiz),
   .sample_strobe (sample_strobe),
   .scan_done     (scan_done),
   .overrun       (overrun)
);

// File: tb/linescan_seq_test.sv
module linescan_seq_test;

   localparam int N     = 64;
   localparam int LEAD  = 37;
   localparam int ENDH  = 8 * N + 36;
   localparam int IW    = $clog2(N);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic line_clk = 1'b0;
   logic line_rst = 1'b0;
   logic m_start = 1'b0;

   logic [IW-1:0] m_idx, s_idx;
   logic m_valid, m_hiz, m_strobe, m_done, m_integ, m_ovr;
   logic s_valid, s_hiz, s_strobe, s_done, s_integ, s_ovr;

   linescan_seq #(.NCH(N)) uut (
      .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_rst(line_rst),
      .slave_mode(1'b0), .start_in(m_start),
      .pix_idx(m_idx), .pix_valid(m_valid), .pix_hiz(m_hiz),
      .sample_strobe(m_strobe), .scan_done(m_done),
      .integ_active(m_integ), .overrun(m_ovr)
   );

   linescan_seq #(.NCH(N)) uut2 (
      .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_rst(line_rst),
      .slave_mode(1'b1), .start_in(m_done),
      .pix_idx(s_idx), .pix_valid(s_valid), .pix_hiz(s_hiz),
      .sample_strobe(s_strobe), .scan_done(s_done),
      .integ_active(s_integ), .overrun(s_ovr)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int  kf = 0, kr = 0;
   bit  seen_fall = 1'b0, seen_rise = 1'b0;
   int  hm = -1000;
   bit  ovr_m = 1'b0, ovr_s = 1'b0;

   task automatic chk(input string what, input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_valid(input int h);
      return (h >= LEAD) && (((h - LEAD) % 8) < 4) && (((h - LEAD) / 8) < N);
   endfunction

   task automatic check_unit(input string who, input string req_start, input string req_win,
                             input int h, input int first_h,
                             input logic [IW-1:0] idx, input logic v, input logic hz,
                             input logic st, input logic dn);
      bit ev;
      ev = exp_valid(h);
      chk({who, " valid"}, req_win, int'(v), int'(ev));
      if (ev) chk({who, " idx"}, req_win, int'(idx), (h - LEAD) / 8);
      chk({who, " strobe"}, (req_win == "R3") ? "R4" : req_win, int'(st),
          int'(ev && (((h - LEAD) % 8) >= 2)));
      chk({who, " done"}, (req_win == "R3") ? "R5" : req_win, int'(dn),
          int'((h >= 8 * N + 32) && (h < ENDH)));
      chk({who, " hiz"}, req_start, int'(hz), int'(!((h >= first_h) && (h < ENDH))));
   endtask

   task automatic tick(input logic rst_val);
      bit rising;
      int hs_prev;
      rising = (line_clk == 1'b0);
      hs_prev = hm - 8 * N + 4;
      line_clk = ~line_clk;
      if (rising && (rst_val != line_rst)) begin
         if (rst_val) begin
            seen_rise = 1'b1;
            kr = 0;
            if ((hm >= 2) && (hm < ENDH)) ovr_m = 1'b1;
            if ((hs_prev >= LEAD) && (hs_prev < ENDH)) ovr_s = 1'b1;
         end else begin
            seen_fall = 1'b1;
            kf = 0;
         end
         line_rst = rst_val;
      end
      if (!rising) begin
         kf++;
         kr++;
      end
      hm = seen_fall ? (rising ? 2 * kf + 1 : 2 * kf) : -1000;
      repeat (3) @(negedge clk);
      // R2 master start, R7 master with start_in held high, R6 follower
      check_unit("master", m_start ? "R7" : "R2", "R3", hm, 2,
                 m_idx, m_valid, m_hiz, m_strobe, m_done);
      check_unit("follower", "R6", "R6", hm - 8 * N + 4, LEAD,
                 s_idx, s_valid, s_hiz, s_strobe, s_done);
      begin
         bit ei;
         ei = line_rst ? (seen_rise && kr >= 8) : (seen_rise && seen_fall && kf < 8);
         chk("master integ", "R8", int'(m_integ), int'(ei));
         chk("follower integ", "R8", int'(s_integ), int'(ei));
      end
      chk("master overrun", "R9", int'(m_ovr), int'(ovr_m));
      chk("follower overrun", "R9", int'(s_ovr), int'(ovr_s));
   endtask

   task automatic run(input int n, input logic lvl);
      for (int i = 0; i < n; i++) tick(lvl);
   endtask

   task automatic check_idle(input string tag);
      chk({tag, " m_valid"}, "R1", int'(m_valid), 0);
      chk({tag, " m_hiz"}, "R1", int'(m_hiz), 1);
      chk({tag, " m_strobe"}, "R1", int'(m_strobe), 0);
      chk({tag, " m_done"}, "R1", int'(m_done), 0);
      chk({tag, " m_integ"}, "R1", int'(m_integ), 0);
      chk({tag, " m_ovr"}, "R1", int'(m_ovr), 0);
      chk({tag, " s_valid"}, "R1", int'(s_valid), 0);
      chk({tag, " s_hiz"}, "R1", int'(s_hiz), 1);
      chk({tag, " s_done"}, "R1", int'(s_done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("in reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_idle("after release");

      // Scan 1: plain master then follower hand-off.
      run(6, 1'b0);
      run(30, 1'b1);
      run(16 * N + 80, 1'b0);

      // Scan 2: master start_in held high (R7), line reset rises inside channel 8 (R9).
      m_start = 1'b1;
      run(30, 1'b1);
      while (hm != 100) tick(1'b0);
      run(16 * N + 80, 1'b1);

      // Scan 3: clean scan after the overrun; flag must stay set.
      run(16 * N + 80, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule